// File: doc/BRIEF.md
# Clock Loss Monitor Reset Generator

This block watches a slow system clock from an independent, free-running reference clock. When the system clock stops, or runs too slowly, it raises a request to the reset sequencer. Every rising edge of the monitored clock is passed through a synchronizer into the reference domain, and each one clears a timeout counter. If the counter reaches `TIMEOUT_CYCLES` reference cycles with no such edge, the block trips. The counter plays the part of an RC timeout, so a frequency floor becomes a fixed count of reference cycles.

Monitoring is gated by an enable input. While the enable is low, nothing is ever reported, and after power-on the block starts with monitoring off. When the enable goes high, the counter starts again from zero, so a long disabled period cannot cause a trip at once. A low-power stop indication tells the block that the monitored clock has been halted on purpose. If monitoring is still on at that point, the block must end up requesting a reset.

Once raised, the request is a level that the reset sequencer turns into a full reset sequence. It stays high until monitoring is disabled or power-on reset is applied.

Top module: `clk_loss_guard`

## Requirements
- R1: When `rst_n` is asserted (low), `rst_req` goes to 0 at once, and the block returns to its disabled state.
- R2: While `mon_en` is 0, `rst_req` stays 0 whatever `mon_clk` does.
- R3: If `mon_en` goes from 0 to 1 while `mon_clk` shows no rising edge, `rst_req` stays 0 through the (TIMEOUT_CYCLES+1)-th rising edge of `ref_clk`. It reads 1 after the (TIMEOUT_CYCLES+2)-th edge. Edges are counted from, and including, the first edge that samples `mon_en` = 1.
- R4: A monitored clock whose rising edges are at most TIMEOUT_CYCLES-4 reference cycles apart never makes `rst_req` rise.
- R5: A monitored clock whose rising edges are TIMEOUT_CYCLES+16 or more reference cycles apart makes `rst_req` rise while `mon_en` is 1.
- R6: Once `rst_req` is 1, it stays 1 for as long as `mon_en` stays 1, even if `mon_clk` recovers.
- R7: `rst_req` returns to 0 on the first `ref_clk` rising edge that samples `mon_en` = 0.
- R8: While `stop_req` is 1 and `mon_en` is 1, monitored edges are ignored. `rst_req` becomes 1 within TIMEOUT_CYCLES+3 reference cycles even if `mon_clk` keeps toggling.
- R9: Each time `mon_en` goes from 0 to 1, the timeout count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mon_clk | input | 1 | Monitored system clock, asynchronous to `ref_clk` |
| mon_en | input | 1 | Monitoring enable, synchronous to `ref_clk` |
| stop_req | input | 1 | Stop-mode indication; the monitored clock is halted on purpose |
| rst_req | output | 1 | Reset request level to the reset sequencer |

## Verification
The hardest case to reach is the stop-mode trip while `mon_clk` is still toggling fast. At the ports it looks like a healthy clock, so only the stop indication can cause the trip. The stimulus keeps a fast monitored clock running with monitoring enabled, then raises `stop_req`. It checks that the request stays low early in the window and is high once the timeout has surely elapsed. The exact timeout cycle is pinned down by freezing the monitored clock for a long disabled period first, and then counting reference edges from the enable rising.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic [1:0] {
    MON_OFF   = 2'd0,
    MON_WATCH = 2'd1,
    MON_TRIP  = 2'd2
  } mon_state_e;

  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/clkmon_rst_sync.sv
module clkmon_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1] & arst_n;
endmodule

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // One flop per stage; stage 0 captures the asynchronous input.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      always_comb d = async_in;
    end else begin : g_rest
      always_comb d = chain_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[LAST];
  end

  assign rise_pulse = chain_q[LAST] & ~last_q;

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/clkmon_timeout.sv
module clkmon_timeout #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic edge_seen,
  input  logic stop_mode,
  output logic expired
);
  import clkmon_pkg::*;
  localparam int CW = cnt_bits(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clear;
  logic          cnt_ce;

  always_comb begin
    clear  = restart | ~active | (edge_seen & ~stop_mode);
    cnt_ce = clear | (cnt_q != LIMIT);
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIMIT);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R8
  stop_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && active && !restart && cnt_q != '0) |=> (cnt_q != '0));
endmodule

// File: rtl/clkmon_req_fsm.sv
module clkmon_req_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic expired,
  output logic active,
  output logic restart,
  output logic req
);
  import clkmon_pkg::*;

  mon_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MON_OFF:   if (enable) state_d = MON_WATCH;
      MON_WATCH: if (!enable) state_d = MON_OFF;
                 else if (expired) state_d = MON_TRIP;
      MON_TRIP:  if (!enable) state_d = MON_OFF;
      default:   state_d = MON_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MON_OFF;
    else        state_q <= state_d;
  end

  assign active  = (state_q != MON_OFF);
  assign restart = (state_q == MON_OFF) & enable;
  assign req     = (state_q == MON_TRIP);

  // R3
  trip_after_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(expired));
endmodule

// File: rtl/clk_loss_guard.sv
module clk_loss_guard #(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_clk,
  input  logic mon_en,
  input  logic stop_req,
  output logic rst_req
);
  logic srst_n;
  logic edge_pulse;
  logic active;
  logic restart;
  logic expired;

  clkmon_rst_sync u_rst (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (ref_clk),
    .rst_n      (srst_n),
    .async_in   (mon_clk),
    .rise_pulse (edge_pulse)
  );

  clkmon_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmo (
    .clk       (ref_clk),
    .rst_n     (srst_n),
    .active    (active),
    .restart   (restart),
    .edge_seen (edge_pulse),
    .stop_mode (stop_req),
    .expired   (expired)
  );

  clkmon_req_fsm u_fsm (
    .clk     (ref_clk),
    .rst_n   (srst_n),
    .enable  (mon_en),
    .expired (expired),
    .active  (active),
    .restart (restart),
    .req     (rst_req)
  );

  // R7
  off_clears_chk: assert property (@(posedge ref_clk) disable iff (!srst_n)
    !mon_en |=> !rst_req);
  // R6
  sticky_req_chk: assert property (@(posedge ref_clk) disable iff (!srst_n)
    (rst_req && mon_en) |=> rst_req);
  // R2
  no_req_when_off_chk: assert property (@(posedge ref_clk) disable iff (!srst_n)
    $rose(rst_req) |-> $past(mon_en));
endmodule

// File: tb/tb_clk_loss_guard.sv
module tb_clk_loss_guard;
  localparam int T = 64;

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_clk = 1'b0;
  logic mon_en = 1'b0;
  logic stop_req = 1'b0;
  logic rst_req;

  int mon_half = 0;
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;
  exp_t q[$];

  clk_loss_guard #(.TIMEOUT_CYCLES(T)) dut (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .mon_clk  (mon_clk),
    .mon_en   (mon_en),
    .stop_req (stop_req),
    .rst_req  (rst_req)
  );

  always #4 ref_clk = ~ref_clk;

  always @(posedge ref_clk) cyc <= cyc + 1;

  // Monitored clock: toggles every mon_half reference cycles, held low when 0.
  initial begin
    int phase;
    phase = 0;
    forever begin
      @(negedge ref_clk);
      if (mon_half == 0) begin
        mon_clk = 1'b0;
        phase = 0;
      end else begin
        phase++;
        if (phase >= mon_half) begin
          mon_clk = ~mon_clk;
          phase = 0;
        end
      end
    end
  end

  // Monitor: pops expectations whose cycle has arrived and compares.
  initial begin
    forever begin
      @(negedge ref_clk);
      #1;
      while (q.size() > 0 && q[0].at <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (rst_req !== e.val) begin
          n_bad++;
          $display("FAIL %s cyc=%0d rst_req actual=%b expected=%b", e.tag, cyc, rst_req, e.val);
        end
      end
    end
  end

  task automatic expect_at(input int dly, input logic v, input string tag);
    exp_t e;
    e.at = cyc + dly;
    e.val = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired, queue=%0d expected=0", q.size());
    finish_run();
  end

  initial begin
    // R1: reset state
    step(1);
    expect_at(1, 1'b0, "R1");
    step(3);
    rst_n = 1'b1;
    step(5);

    // R2: disabled, clock stopped then slow
    expect_at(50, 1'b0, "R2");
    expect_at(150, 1'b0, "R2");
    mon_half = 0;
    step(160);
    mon_half = 100;
    expect_at(290, 1'b0, "R2");
    step(300);
    mon_half = 0;
    step(10);

    // R3 / R9: exact timeout after enable rising, clock frozen
    mon_en = 1'b1;
    expect_at(T + 1, 1'b0, "R3");
    expect_at(T + 2, 1'b1, "R3");
    expect_at(T + 2, 1'b1, "R9");
    step(T + 5);

    // R6: request stays set after clock recovers
    mon_half = 3;
    expect_at(20, 1'b1, "R6");
    expect_at(60, 1'b1, "R6");
    expect_at(100, 1'b1, "R6");
    step(110);

    // R7: disabling clears request on next edge
    mon_en = 1'b0;
    expect_at(1, 1'b0, "R7");
    step(5);

    // R4: edges every T-4 cycles never trip
    mon_half = (T - 4) / 2;
    step(2);
    mon_en = 1'b1;
    expect_at(100, 1'b0, "R4");
    expect_at(300, 1'b0, "R4");
    expect_at(600, 1'b0, "R4");
    expect_at(900, 1'b0, "R4");
    step(1000);

    // R5: edges T+16 apart trip
    mon_half = (T + 16) / 2;
    expect_at(3 * T, 1'b1, "R5");
    step(3 * T + 5);
    mon_en = 1'b0;
    expect_at(1, 1'b0, "R7");
    step(5);

    // R8: stop mode ignores a fast clock
    mon_half = 3;
    mon_en = 1'b1;
    expect_at(19, 1'b0, "R8");
    step(20);
    stop_req = 1'b1;
    expect_at(T - 15, 1'b0, "R8");
    expect_at(T + 3, 1'b1, "R8");
    step(T + 6);
    stop_req = 1'b0;
    mon_en = 1'b0;
    expect_at(1, 1'b0, "R7");
    step(5);

    // R1: asynchronous reset clears a tripped request
    mon_half = 0;
    mon_en = 1'b1;
    step(T + 10);
    expect_at(0, 1'b1, "R6");
    step(1);
    rst_n = 1'b0;
    #1;
    n_cmp++;
    if (rst_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 async clear actual=%b expected=0", rst_req);
    end
    step(3);
    mon_en = 1'b0;
    rst_n = 1'b1;
    expect_at(10, 1'b0, "R1");
    step(15);

    while (q.size() > 0) step(1);
    step(2);
    finish_run();
  end
endmodule